// File: doc/BRIEF.md
# PLL Control and Status Register

This block is the eight-bit control and status register of a clock-generation unit. Software reaches it over a simple register bus that has an address match, a read strobe, a write strobe and write data. The register holds an interrupt enable, a lock-change flag, a PLL power bit, a base-clock source request and a two-bit VCO range field. Its outputs drive the PLL enable, the request to the base clock selector, the VCO range and an interrupt line.

The lock detector's output enters the block asynchronously. A two-flop synchronizer samples it, and each change of level, rising or falling, sets the flag. Reading the register clears the flag. An auto-bandwidth input comes from a neighbouring register. While that input is low, the enable and the flag are hidden and the enable is frozen.

The power bit and the select bit guard each other, so the VCO clock can never be chosen while the PLL is off. Both interlock checks use the register contents from before the write.

Top module: `pll_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x20: the PLL power bit is 1 and all other bits are 0. `pll_enable` is 1, `base_sel_req` is 0, `vco_range` is 0 and `irq` is 0.
- R2: The fields sit at these positions: bit 7 is the interrupt enable, bit 6 the lock-change flag, bit 5 PLL power, bit 4 base-clock select, and bits 1:0 the VCO range. A write to bits 1:0 reads back unchanged.
- R3: Bits 3 and 2 always read as 0, and writing to them has no effect.
- R4: Any level change on `lock_async` sets the flag. The flag becomes visible on the third rising clock edge after the change.
- R5: Writes do not affect the flag. Writing 1 does not set it and writing 0 does not clear it.
- R6: A read strobe clears the flag. If a lock change reaches the flag on the same edge as a clearing read, the flag stays set.
- R7: While `auto_bw` is 0, writes leave the stored enable unchanged, bits 7 and 6 read as 0, and `irq` is 0.
- R8: `irq` is 1 when the flag, the enable and `auto_bw` are all 1.
- R9: A write that clears bit 5 has no effect on that bit if, before the write, bit 4 was 1 or if the same write sets bit 4.
- R10: A write that sets bit 4 has no effect on that bit if bit 5 was 0 before the write. When one write sets both bits starting from 0, only bit 5 changes.
- R11: `pll_enable`, `base_sel_req` and `vco_range` follow bits 5, 4 and 1:0. They change only on a cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Address match for this register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; zero when no read is selected |
| lock_async | input | 1 | Lock indication from the PLL, asynchronous |
| auto_bw | input | 1 | Auto-bandwidth mode from the bandwidth register |
| irq | output | 1 | Lock-change interrupt request |
| pll_enable | output | 1 | PLL power enable |
| base_sel_req | output | 1 | Request to take the base clock from the VCO |
| vco_range | output | 2 | VCO power-of-two range |

## Verification
The assertions assume that `lock_async` is low while reset is held, so the synchronizer does not report a change when reset is released. They also assume that the strobes are only meaningful while `sel` is high. The bench holds `lock_async` at 0 throughout reset. It changes the input only at falling clock edges, and it asserts `rd_en` or `wr_en` only together with `sel`. The interlock assertions depend on the reset values being legal (power 1, select 0), and the bench's reset check confirms these values before any write.

// File: rtl/pctl_pkg.sv
// Package: shared widths and bit positions of the PLL control register.
// Assumes an eight-bit register with the field layout listed in the brief.
package pctl_pkg;
    localparam int REG_W    = 8;
    localparam int VCO_W    = 2;
    localparam int IEN_BIT  = 7;
    localparam int FLAG_BIT = 6;
    localparam int ON_BIT   = 5;
    localparam int SEL_BIT  = 4;
    localparam int VCO_LSB  = 0;
    localparam int SYNC_N   = 2;
endpackage

// File: rtl/lock_edge_sync.sv
// Module: synchronizes an asynchronous level and pulses on each change.
// Assumes the input is low during reset; STAGES must be 2 or more.
module lock_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic toggle
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Keep the previous synchronized level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign toggle = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/lock_flag.sv
// Module: lock-change flag, set by a change pulse and cleared by a read.
// Assumes a set and a clear on the same edge resolve in favour of the set.
module lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic rd_clear,
    output logic flag_q
);
    // Set has priority over the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (set_pulse) flag_q <= 1'b1;
        else if (rd_clear)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/pctl_fields.sv
// Module: writable fields of the PLL control register and their interlocks.
// Assumes both interlock checks use the contents held before the write.
module pctl_fields
    import pctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             auto_bw,
    output logic             ien_q,
    output logic             on_q,
    output logic             sel_q,
    output logic [VCO_W-1:0] vco_q
);
    logic sel_next;
    logic on_next;

    // Select may rise only while power was already on before the write.
    always_comb begin
        sel_next = wdata[SEL_BIT];
        if (wdata[SEL_BIT] && !on_q) sel_next = 1'b0;
    end

    // Power may drop only if select was clear and stays clear.
    always_comb begin
        on_next = wdata[ON_BIT];
        if (!wdata[ON_BIT] && (sel_q || sel_next)) on_next = 1'b1;
    end

    // Enable is writable only in auto-bandwidth mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ien_q <= 1'b0;
        else if (wr_hit && auto_bw)  ien_q <= wdata[IEN_BIT];
    end

    // Power, select and range update together on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q  <= 1'b1;
            sel_q <= 1'b0;
            vco_q <= '0;
        end else if (wr_hit) begin
            on_q  <= on_next;
            sel_q <= sel_next;
            vco_q <= wdata[VCO_LSB +: VCO_W];
        end
    end
endmodule

// File: rtl/pll_ctrl_reg.sv
// Module: top of the PLL control register. It decodes bus strobes,
// assembles read data and drives the interrupt and clock-control outputs.
// Assumes rd_en and wr_en matter only when sel is high.
module pll_ctrl_reg
    import pctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             lock_async,
    input  logic             auto_bw,
    output logic             irq,
    output logic             pll_enable,
    output logic             base_sel_req,
    output logic [VCO_W-1:0] vco_range
);
    logic             rd_hit;
    logic             wr_hit;
    logic             lock_toggle;
    logic             flag_q;
    logic             ien_q;
    logic             on_q;
    logic             sel_q;
    logic [VCO_W-1:0] vco_q;
    logic [REG_W-1:0] view;

    assign rd_hit = sel && rd_en;
    assign wr_hit = sel && wr_en;

    lock_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lock_async),
        .toggle   (lock_toggle)
    );

    lock_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (lock_toggle),
        .rd_clear  (rd_hit),
        .flag_q    (flag_q)
    );

    pctl_fields u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (wdata),
        .auto_bw (auto_bw),
        .ien_q   (ien_q),
        .on_q    (on_q),
        .sel_q   (sel_q),
        .vco_q   (vco_q)
    );

    // Build the software view; hidden bits and reserved bits read as zero.
    always_comb begin
        view                      = '0;
        view[IEN_BIT]             = ien_q && auto_bw;
        view[FLAG_BIT]            = flag_q && auto_bw;
        view[ON_BIT]              = on_q;
        view[SEL_BIT]             = sel_q;
        view[VCO_LSB +: VCO_W]    = vco_q;
    end

    assign rdata        = rd_hit ? view : '0;
    assign irq          = flag_q && ien_q && auto_bw;
    assign pll_enable   = on_q;
    assign base_sel_req = sel_q;
    assign vco_range    = vco_q;
endmodule

// File: rtl/pll_ctrl_reg_chk.sv
// Module: assertion checker for pll_ctrl_reg, bound to every instance.
// Assumes lock_async is low during reset.
module pll_ctrl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       rd_en,
    input logic       wr_en,
    input logic       auto_bw,
    input logic       lock_toggle,
    input logic       irq,
    input logic       pll_enable,
    input logic       base_sel_req,
    input logic [1:0] vco_range,
    input logic [7:0] rdata
);
    // R9
    sel_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_sel_req |-> pll_enable);

    // R10
    sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(base_sel_req) |-> $past(pll_enable));

    // R11
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr_en) |=> ($stable(pll_enable) && $stable(base_sel_req) && $stable(vco_range)));

    // R7
    irq_needs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> auto_bw);

    // R7
    hidden_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_bw |-> (rdata[7:6] == 2'b00));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[3:2] == 2'b00);

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_en && !lock_toggle) |=> !irq);
endmodule

bind pll_ctrl_reg pll_ctrl_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (sel),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .auto_bw      (auto_bw),
    .lock_toggle  (lock_toggle),
    .irq          (irq),
    .pll_enable   (pll_enable),
    .base_sel_req (base_sel_req),
    .vco_range    (vco_range),
    .rdata        (rdata)
);

// File: tb/pll_ctrl_reg_test.sv
// Bench: table-driven register writes and readbacks, then directed tests
// for lock changes, flag clearing, auto-mode gating and interlocks.
module pll_ctrl_reg_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel, rd_en, wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       lock_async, auto_bw;
    logic       irq, pll_enable, base_sel_req;
    logic [1:0] vco_range;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    // Write data in the high byte, expected readback in the low byte.
    localparam logic [15:0] VEC [0:9] = '{
        16'h2323, 16'h3C30, 16'h0121, 16'h0000, 16'h1202,
        16'h3020, 16'h1030, 16'hC0A0, 16'h0000, 16'h2020
    };

    always #2.5 clk = ~clk;

    pll_ctrl_reg uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .lock_async(lock_async), .auto_bw(auto_bw),
        .irq(irq), .pll_enable(pll_enable), .base_sel_req(base_sel_req),
        .vco_range(vco_range)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        sel = 1'b1; wr_en = 1'b1; wdata = d;
        tick();
        sel = 1'b0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input string tag, input logic [7:0] exp);
        sel = 1'b1; rd_en = 1'b1;
        #1 check(tag, rdata, exp);
        tick();
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        sel = 0; rd_en = 0; wr_en = 0; wdata = '0;
        lock_async = 0; auto_bw = 1; rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        check("R1 pll_enable", {7'd0, pll_enable}, 8'h01);
        check("R1 base_sel_req", {7'd0, base_sel_req}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 vco_range", {6'd0, vco_range}, 8'h00);
        do_read("R1 readback", 8'h20);

        // R2 R3 R9 R10 R11 table of writes and readbacks
        for (int i = 0; i < 10; i++) begin
            do_write(VEC[i][15:8]);
            check("R11 outputs", {2'b00, pll_enable, base_sel_req, 2'b00, vco_range},
                  {2'b00, VEC[i][5], VEC[i][4], 2'b00, VEC[i][1:0]});
            do_read("R2 R3 R9 R10 table", VEC[i][7:0]);
        end

        // R4 R8 rising change, visible on the third edge
        do_write(8'hA0);
        lock_async = 1'b1;
        tick(); tick();
        check("R4 sync delay", {7'd0, irq}, 8'h00);
        tick();
        check("R4 R8 rise irq", {7'd0, irq}, 8'h01);
        do_read("R6 read shows flag", 8'hE0);
        check("R6 cleared irq", {7'd0, irq}, 8'h00);

        // R4 falling change
        lock_async = 1'b0;
        tick(); tick(); tick();
        check("R4 fall irq", {7'd0, irq}, 8'h01);

        // R5 writes leave the flag alone
        do_write(8'hA0);
        do_read("R5 zero write kept flag", 8'hE0);
        do_write(8'hE0);
        do_read("R5 one write no set", 8'hA0);

        // R6 change arriving with a clearing read keeps the flag
        lock_async = 1'b1;
        tick(); tick(); tick();
        lock_async = 1'b0;
        tick(); tick();
        do_read("R6 coincident read", 8'hE0);
        check("R6 coincident irq", {7'd0, irq}, 8'h01);
        do_read("R6 second read", 8'hE0);
        check("R6 second clear", {7'd0, irq}, 8'h00);

        // R7 auto mode low hides bits and blocks enable writes
        auto_bw = 1'b0;
        lock_async = 1'b1;
        tick(); tick(); tick();
        check("R7 irq gated", {7'd0, irq}, 8'h00);
        do_read("R7 hidden bits", 8'h20);
        do_write(8'h20);
        auto_bw = 1'b1;
        #1 check("R7 irq after read", {7'd0, irq}, 8'h00);
        do_read("R7 enable held", 8'hA0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule